// File: doc/BRIEF.md
# Coalescing Store Buffer

This block holds stores on their way from a cache to memory. Each slot tracks one memory block: its block address, a copy of the block's bytes and a per-byte valid mask. A store to a block that already has a slot is folded into that slot. A store to any other block opens a new slot, and the store is held off when every slot is in use. Slots leave in the order they were opened. Each one goes out as a single block write carrying a byte mask, so several small stores to one block reach memory as one transfer.

Loads that missed in the cache have first claim on memory. While the load-miss request line is high the buffer puts out no write at all. The same load can also look up the buffer. If a slot for its block holds every byte the load needs, the buffer reports a hit and returns those bytes. If the slot holds only some of them, the buffer tells the load to wait until that slot has drained.

The slot count must be a power of two. Byte k of a block is lane k: data bits [8k+7:8k] and enable or mask bit k. The block offset bits of a store or load address do not choose a lane; they only drop out of the block address.

Top module: `coalescing_store_buffer`

## Requirements
- R1: After reset no slot is in use: `mem_wr_valid` is 0 and `st_ready` is 1. With `ld_valid` low, `ld_hit` and `ld_wait` are 0.
- R2: A store accepted (`st_valid` and `st_ready` high at a clock edge) to a block with no slot opens a new slot. Its mask equals `st_be`, and byte k holds `st_data[8k+7:8k]` wherever `st_be[k]` is 1.
- R3: A store accepted to a block that already has a slot updates that slot. The enabled bytes are overwritten, the enables are ORed into the mask, and no new slot is opened. Two in-use slots never share a block address.
- R4: When every slot is in use, a store to a block with no slot sees `st_ready` low. A store to a block that already has a slot is still accepted.
- R5: Slots drain in the order they were opened, one slot per accepted write (`mem_wr_valid` and `mem_wr_ready` high at a clock edge). `mem_wr_addr` is the block address with its low log2(BLOCK_BYTES) bits zero. The masked `mem_wr_data` and `mem_wr_mask` equal the slot's bytes and mask. The address is held while a write is stalled.
- R6: While `lmiss_req` is high, `mem_wr_valid` is 0 and no slot drains.
- R7: When `ld_valid` is high and a slot for the load's block has every byte set in `ld_be` valid, `ld_hit` is 1. In the same cycle `ld_data` carries that slot's bytes on their lanes. The lookup sees the slot contents as of the last clock edge.
- R8: When a matching slot lacks any byte set in `ld_be`, `ld_wait` is 1 and `ld_hit` is 0. When no slot matches, both are 0.
- R9: A store to the block whose slot drains at the same clock edge sees `st_ready` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | BLOCK_BYTES*8 | Store data, lane-aligned within the block |
| st_be | input | BLOCK_BYTES | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load byte address |
| ld_be | input | BLOCK_BYTES | Bytes the load needs |
| ld_hit | output | 1 | All needed bytes are buffered |
| ld_wait | output | 1 | Block is buffered but only partly valid |
| ld_data | output | BLOCK_BYTES*8 | Buffered bytes of the matching slot |
| lmiss_req | input | 1 | A load miss is requesting memory |
| mem_wr_valid | output | 1 | Block write offered to memory |
| mem_wr_ready | input | 1 | Memory accepts the block write |
| mem_wr_addr | output | ADDR_W | Block-aligned write address |
| mem_wr_data | output | BLOCK_BYTES*8 | Block write data |
| mem_wr_mask | output | BLOCK_BYTES | Byte mask of the block write |

## Verification
The assertions assume that the store, load and memory-side inputs are steady and defined around each clock edge. They also assume that `lmiss_req` and `mem_wr_ready` are the only things that hold back a drain. The bench drives every input half a cycle away from the active edge. It changes the memory-side controls only at falling edges, and it offers stores only through a task that holds the request until `st_ready` is seen. For the full-buffer and same-edge-drain cases it probes `st_ready` and then withdraws the request before the edge, so no unintended store is ever taken.

// File: rtl/coalescing_store_buffer.sv
`timescale 1ns/1ps
module coalescing_store_buffer #(
  parameter int ENTRIES     = 4,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  output logic                     st_ready,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [BLOCK_BYTES*8-1:0] st_data,
  input  logic [BLOCK_BYTES-1:0]   st_be,
  input  logic                     ld_valid,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [BLOCK_BYTES-1:0]   ld_be,
  output logic                     ld_hit,
  output logic                     ld_wait,
  output logic [BLOCK_BYTES*8-1:0] ld_data,
  input  logic                     lmiss_req,
  output logic                     mem_wr_valid,
  input  logic                     mem_wr_ready,
  output logic [ADDR_W-1:0]        mem_wr_addr,
  output logic [BLOCK_BYTES*8-1:0] mem_wr_data,
  output logic [BLOCK_BYTES-1:0]   mem_wr_mask
);
  localparam int DATA_W = BLOCK_BYTES * 8;
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W:0] FULL = (PTR_W+1)'(ENTRIES);

  logic [ENTRIES-1:0]     ent_v;
  logic [TAG_W-1:0]       ent_tag  [ENTRIES];
  logic [DATA_W-1:0]      ent_data [ENTRIES];
  logic [BLOCK_BYTES-1:0] ent_mask [ENTRIES];
  logic [PTR_W-1:0]       head, tail, st_idx, wr_idx;
  logic [PTR_W:0]         occ;
  logic [ENTRIES-1:0]     st_hitv, ld_hitv, ld_cov;
  logic [TAG_W-1:0]       st_tag, ld_tag;
  logic                   st_match, st_fire, alloc, drain_fire, dup;

  assign st_tag = st_addr[ADDR_W-1:OFF_W];
  assign ld_tag = ld_addr[ADDR_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign st_hitv[i] = ent_v[i] && (ent_tag[i] == st_tag);
    assign ld_hitv[i] = ent_v[i] && (ent_tag[i] == ld_tag);
    assign ld_cov[i]  = ld_hitv[i] && ((ld_be & ~ent_mask[i]) == '0);
  end

  always_comb begin
    st_idx  = '0;
    ld_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (st_hitv[i]) st_idx = PTR_W'(i);
      if (ld_hitv[i]) ld_data = ent_data[i];
    end
  end

  assign st_match     = |st_hitv;
  assign mem_wr_valid = ent_v[head] && !lmiss_req;
  assign mem_wr_addr  = {ent_tag[head], {OFF_W{1'b0}}};
  assign mem_wr_data  = ent_data[head];
  assign mem_wr_mask  = ent_mask[head];
  assign drain_fire   = mem_wr_valid && mem_wr_ready;
  assign st_ready     = st_match ? !(drain_fire && st_idx == head) : (occ != FULL);
  assign st_fire      = st_valid && st_ready;
  assign alloc        = st_fire && !st_match;
  assign wr_idx       = st_match ? st_idx : tail;
  assign ld_hit       = ld_valid && |ld_cov;
  assign ld_wait      = ld_valid && |ld_hitv && !(|ld_cov);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
      head  <= '0;
      tail  <= '0;
      occ   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_tag[i]  <= '0;
        ent_data[i] <= '0;
        ent_mask[i] <= '0;
      end
    end else begin
      if (drain_fire) begin
        ent_v[head] <= 1'b0;
        head        <= head + PTR_W'(1);
      end
      if (st_fire) begin
        ent_v[wr_idx]    <= 1'b1;
        ent_tag[wr_idx]  <= st_tag;
        ent_mask[wr_idx] <= (st_match ? ent_mask[wr_idx] : '0) | st_be;
        for (int b = 0; b < BLOCK_BYTES; b++)
          if (st_be[b]) ent_data[wr_idx][8*b +: 8] <= st_data[8*b +: 8];
      end
      if (alloc) tail <= tail + PTR_W'(1);
      occ <= occ + (PTR_W+1)'(alloc) - (PTR_W+1)'(drain_fire);
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (ent_v[i] && ent_v[j] && ent_tag[i] == ent_tag[j]) dup = 1'b1;
  end

  a_r3_one_slot_per_block: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);
  a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !drain_fire) |=> occ == $past(occ) + 1'b1);
  a_r3_merge_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && st_match && !drain_fire) |=> occ == $past(occ));
  a_r4_count_tracks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    int'($countones(ent_v)) == int'(occ));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);
  a_r6_head_held_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    lmiss_req |=> $stable(head));
  a_r5_addr_held_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> $stable(mem_wr_addr));
  a_r8_hit_wait_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_wait));
endmodule

// File: tb/coalescing_store_buffer_tb.sv
`timescale 1ns/1ps
module coalescing_store_buffer_tb;
  localparam int ENTRIES = 4;
  localparam int AW = 32;
  localparam int BB = 16;
  localparam int DW = BB * 8;
  localparam int OFF = 4;

  typedef struct {
    logic [AW-OFF-1:0] blk;
    logic [DW-1:0]     data;
    logic [BB-1:0]     mask;
  } ent_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, ld_valid = 1'b0, lmiss_req = 1'b0, mem_wr_ready = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BB-1:0] st_be = '0, ld_be = '0;
  logic st_ready, ld_hit, ld_wait, mem_wr_valid;
  logic [DW-1:0] ld_data, mem_wr_data;
  logic [AW-1:0] mem_wr_addr;
  logic [BB-1:0] mem_wr_mask;

  ent_t model[$];
  int vectors = 0, errors = 0, drained = 0;

  always #2 clk = ~clk;

  coalescing_store_buffer #(.ENTRIES(ENTRIES), .ADDR_W(AW), .BLOCK_BYTES(BB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_hit(ld_hit), .ld_wait(ld_wait), .ld_data(ld_data),
    .lmiss_req(lmiss_req),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] widen(input logic [BB-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < BB; b++) r[8*b +: 8] = {8{m[b]}};
    return r;
  endfunction

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < model.size(); i++)
      if (model[i].blk == a[AW-1:OFF]) return i;
    return -1;
  endfunction

  function automatic logic [DW-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BB-1:0] be);
    int idx;
    ent_t e;
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    forever begin
      #1;
      if (st_ready) break;
      @(negedge clk);
    end
    idx = find(a);
    if (idx >= 0) begin
      model[idx].data = (model[idx].data & ~widen(be)) | (d & widen(be));
      model[idx].mask = model[idx].mask | be;
    end else begin
      e.blk = a[AW-1:OFF]; e.data = d & widen(be); e.mask = be;
      model.push_back(e);
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic peek_store(input logic [AW-1:0] a, input logic [BB-1:0] be,
                            input logic exp_ready, input string req);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = rnd128(); st_be = be;
    #1;
    check(st_ready == exp_ready, req, "st_ready", DW'(st_ready), DW'(exp_ready));
    st_valid = 1'b0;
  endtask

  task automatic load_probe(input logic [AW-1:0] a, input logic [BB-1:0] be, input string req);
    int idx;
    logic eh, ew;
    idx = find(a);
    eh = (idx >= 0) && ((be & ~model[idx].mask) == '0);
    ew = (idx >= 0) && !eh;
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_be = be;
    #1;
    check(ld_hit == eh, req, "ld_hit", DW'(ld_hit), DW'(eh));
    check(ld_wait == ew, req, "ld_wait", DW'(ld_wait), DW'(ew));
    if (eh)
      check((ld_data & widen(be)) == (model[idx].data & widen(be)), req, "ld_data",
            ld_data & widen(be), model[idx].data & widen(be));
    ld_valid = 1'b0;
  endtask

  // Monitor: scoreboard of expected block writes, oldest first
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n) begin
      if (lmiss_req) check(!mem_wr_valid, "R6", "write offered under load miss", DW'(mem_wr_valid), '0);
      if (mem_wr_valid && mem_wr_ready) begin
        if (model.size() == 0) begin
          check(1'b0, "R5", "unexpected block write", DW'(mem_wr_addr), '0);
        end else begin
          check(mem_wr_addr == {model[0].blk, 4'h0}, "R5", "write address",
                DW'(mem_wr_addr), DW'({model[0].blk, 4'h0}));
          check(mem_wr_mask == model[0].mask, "R5", "write mask",
                DW'(mem_wr_mask), DW'(model[0].mask));
          check((mem_wr_data & widen(mem_wr_mask)) == model[0].data, "R5", "write data",
                mem_wr_data & widen(mem_wr_mask), model[0].data);
          void'(model.pop_front());
          drained++;
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R5 watchdog expired act=%0d exp=%0d", drained, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic drain_all(input string req);
    @(negedge clk);
    lmiss_req = 1'b0; mem_wr_ready = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (model.size() == 0) break;
    end
    #1;
    check(model.size() == 0, req, "buffer not emptied", DW'(model.size()), '0);
    check(!mem_wr_valid, req, "write still offered when empty", DW'(mem_wr_valid), '0);
  endtask

  initial begin
    logic [AW-1:0] blks [6];
    repeat (3) @(negedge clk);
    #1;
    check(!mem_wr_valid, "R1", "mem_wr_valid in reset", DW'(mem_wr_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(st_ready, "R1", "st_ready after reset", DW'(st_ready), 1);
    check(!mem_wr_valid, "R1", "mem_wr_valid after reset", DW'(mem_wr_valid), '0);
    check(!ld_hit && !ld_wait, "R1", "load flags after reset", DW'({ld_hit, ld_wait}), '0);

    // R2/R3: allocate and merge with memory held off
    do_store(32'h0000_1000, rnd128(), 16'h000F);
    do_store(32'h0000_2004, rnd128(), 16'hF000);
    do_store(32'h0000_1008, rnd128(), 16'h00F8);
    load_probe(32'h0000_1000, 16'h00FF, "R3");
    load_probe(32'h0000_2000, 16'hF000, "R2");
    do_store(32'h0000_3000, rnd128(), 16'h0FF0);
    do_store(32'h0000_4000, rnd128(), 16'hFFFF);
    // R4: full buffer
    peek_store(32'h0000_5000, 16'h0001, 1'b0, "R4");
    do_store(32'h0000_2000, rnd128(), 16'h0F00);
    load_probe(32'h0000_2000, 16'hFF00, "R4");
    // R7/R8 lookups
    load_probe(32'h0000_3000, 16'h0030, "R7");
    load_probe(32'h0000_4000, 16'hFFFF, "R7");
    load_probe(32'h0000_1000, 16'h0100, "R8");
    load_probe(32'h0000_9000, 16'h0001, "R8");
    // R6: load miss blocks draining
    @(negedge clk);
    lmiss_req = 1'b1; mem_wr_ready = 1'b1;
    repeat (6) @(negedge clk);
    check(drained == 0, "R6", "drained under load miss", DW'(drained), '0);
    drain_all("R5");
    check(drained == 4, "R5", "block write count", DW'(drained), 4);
    peek_store(32'h0000_5000, 16'h0001, 1'b1, "R1");

    // R9: store to the slot draining at the same edge
    @(negedge clk);
    lmiss_req = 1'b1;
    do_store(32'h0000_6000, rnd128(), 16'h0003);
    @(negedge clk);
    lmiss_req = 1'b0;
    st_valid = 1'b1; st_addr = 32'h0000_6000; st_data = rnd128(); st_be = 16'h0004;
    #1;
    check(!st_ready, "R9", "st_ready on draining slot", DW'(st_ready), '0);
    st_valid = 1'b0;
    @(negedge clk);
    #1;
    check(model.size() == 0, "R9", "slot drained", DW'(model.size()), '0);
    do_store(32'h0000_6000, rnd128(), 16'h0004);
    drain_all("R9");

    // Mixed traffic: merges, stalls, lookups, then drain under a toggling load miss
    for (int k = 0; k < 6; k++) blks[k] = 32'h0001_0000 + 32'(k) * 32'h40;
    @(negedge clk);
    mem_wr_ready = 1'b0;
    for (int it = 0; it < 40; it++) begin
      logic [AW-1:0] a;
      logic [BB-1:0] be;
      a  = blks[$urandom % 6];
      be = BB'($urandom);
      if (be == '0) be = 16'h0001;
      if (model.size() == ENTRIES && find(a) < 0) peek_store(a, be, 1'b0, "R4");
      else do_store(a, rnd128(), be);
      if (it % 3 == 0) load_probe(blks[$urandom % 6], BB'($urandom), "R7");
    end
    @(negedge clk);
    mem_wr_ready = 1'b1;
    for (int c = 0; c < 60 && model.size() != 0; c++) begin
      @(negedge clk);
      lmiss_req = (c % 4 == 0);
    end
    drain_all("R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule